// File: doc/BRIEF.md
# Peripheral Reset and Clock-Gate Sequencer

This block owns the reset line and the clock-gate enable of one peripheral. Software, or any other master, drives them through four write-only action registers: one sets reset, one clears reset, one opens the clock gate and one closes it. Two status registers return the acknowledgements that the peripheral side sends back. Each acknowledgement passes through a synchronizer of configurable depth, so status lags the applied state by a number of cycles.

A hardware sequencer runs a complete reset cycle on a single start pulse. It applies reset, then stops the clock, then removes reset, then restarts the clock. It issues no step until the status of the previous step has reached its target value. Every wait has its own cycle budget. If a budget runs out, the sequence stops where it is, raises an error flag and reports the index of the step that stalled.

Top module: `rcs_sequencer`

## Requirements
- R1: After reset, `rst_out` is 0, `clken_out` is 1, and `seq_busy`, `seq_done`, `seq_err` and `seq_err_step` are all 0.
- R2: A write with `reg_we`=1 while idle acts on the next clock edge when bit 0 of `reg_wdata` is 1. Index 0 sets `clken_out`, index 1 clears `clken_out`, index 2 sets `rst_out`, index 3 clears `rst_out`. A write with bit 0 equal to 0 leaves both outputs unchanged.
- R3: `reg_rdata` is combinational from `reg_addr`. Index 4 returns the clock acknowledgement and index 5 returns the reset acknowledgement, each in bit 0 and each delayed by SYNC_STAGES flops. Indices 0 to 3 and all unused indices read 0, and so do all bits above bit 0.
- R4: A `seq_start` pulse while idle runs four steps in a fixed order. Step 0 sets reset and waits for reset status 1. Step 1 closes the gate and waits for clock status 0. Step 2 releases reset and waits for reset status 0. Step 3 opens the gate and waits for clock status 1.
- R5: Step 0 is applied on the edge that samples `seq_start`. Each later step is applied on the edge after the cycle in which the previous step's status matched. With acknowledgements arriving A edges after an output change, a clean run ends 4·(A+SYNC_STAGES+1) edges after the start edge. `seq_busy` is 1 throughout the run, and `seq_done` rises on the same edge that `seq_busy` falls.
- R6: A step whose status does not match within TIMEOUT wait cycles ends the run TIMEOUT edges after that step was applied. At that point `seq_busy` falls, `seq_err` is set and `seq_err_step` holds the step index (0 to 3 as in R4). The outputs keep their present values.
- R7: `seq_done` and `seq_err` are never both 1. Both are cleared by the next accepted start.
- R8: While `seq_busy` is 1, register writes and further start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Write data, bit 0 significant |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| seq_start | input | 1 | Start a full reset cycle |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | Last sequence completed |
| seq_err | output | 1 | Last sequence timed out |
| seq_err_step | output | 2 | Index of the step that timed out |
| rst_out | output | 1 | Reset applied to the peripheral |
| clken_out | output | 1 | Clock-gate enable for the peripheral |
| rst_ack_in | input | 1 | Reset acknowledgement from the peripheral |
| clk_ack_in | input | 1 | Clock acknowledgement from the peripheral |

## Verification
The bench sweeps the peripheral's acknowledgement latency over four values, with every step allowed to succeed, and checks the exact completion cycle. Matching it shows that each step waits for its own status rather than for a fixed delay. The bench then repeats the sweep with the acknowledgement of each step frozen in turn. The cycle at which the error appears, together with the reported step index, distinguishes a wrong step order, a wrong expected polarity and an off-by-one timeout budget. Writes and start pulses injected mid-run, together with a full address sweep of reads, cover the decode and the lock-out.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   localparam int IDX_CLK_ON  = 0;
   localparam int IDX_CLK_OFF = 1;
   localparam int IDX_RST_ON  = 2;
   localparam int IDX_RST_OFF = 3;
   localparam int IDX_CLK_ST  = 4;
   localparam int IDX_RST_ST  = 5;

   typedef enum logic {S_IDLE, S_WAIT} seq_state_t;

   typedef struct packed {
      logic rst_on;
      logic rst_off;
      logic clk_on;
      logic clk_off;
   } rcs_act_t;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
   import rcs_pkg::*;
#(
   parameter int TIMEOUT = 1000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rst_stat,
   input  logic       clk_stat,
   output rcs_act_t   act,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic [1:0] err_step
);
   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

   seq_state_t    state;
   logic [1:0]    step;
   logic [CW-1:0] cnt;
   logic          match;

   always_comb begin
      case (step)
         2'd0:    match = rst_stat;
         2'd1:    match = !clk_stat;
         2'd2:    match = !rst_stat;
         default: match = clk_stat;
      endcase
   end

   always_comb begin
      act = '0;
      if (state == S_IDLE && start) begin
         act.rst_on = 1'b1;
      end else if (state == S_WAIT && match) begin
         case (step)
            2'd0:    act.clk_off = 1'b1;
            2'd1:    act.rst_off = 1'b1;
            2'd2:    act.clk_on  = 1'b1;
            default: act = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step     <= 2'd0;
         cnt      <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         err_step <= 2'd0;
      end else if (state == S_IDLE) begin
         if (start) begin
            state    <= S_WAIT;
            step     <= 2'd0;
            cnt      <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_step <= 2'd0;
         end
      end else if (match) begin
         cnt <= '0;
         if (step == 2'd3) begin
            state <= S_IDLE;
            done  <= 1'b1;
         end else begin
            step <= step + 2'd1;
         end
      end else if (cnt == CNT_LAST) begin
         state    <= S_IDLE;
         err      <= 1'b1;
         err_step <= step;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign busy = (state == S_WAIT);

   // R7
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= CNT_LAST));
   // R4
   act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act));
   // R5
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!busy && $past(busy)));
   // R6
   err_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(err_step));
endmodule

// File: rtl/rcs_regs.sv
module rcs_regs
   import rcs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  rcs_act_t          act,
   input  logic              rst_stat,
   input  logic              clk_stat,
   output logic              rst_out,
   output logic              clken_out,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_CLK_ON  = ADDR_W'(IDX_CLK_ON);
   localparam logic [ADDR_W-1:0] A_CLK_OFF = ADDR_W'(IDX_CLK_OFF);
   localparam logic [ADDR_W-1:0] A_RST_ON  = ADDR_W'(IDX_RST_ON);
   localparam logic [ADDR_W-1:0] A_RST_OFF = ADDR_W'(IDX_RST_OFF);
   localparam logic [ADDR_W-1:0] A_CLK_ST  = ADDR_W'(IDX_CLK_ST);
   localparam logic [ADDR_W-1:0] A_RST_ST  = ADDR_W'(IDX_RST_ST);

   logic wr_ok;
   assign wr_ok = we && !busy && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_out   <= 1'b0;
         clken_out <= 1'b1;
      end else begin
         if (act.rst_on || (wr_ok && addr == A_RST_ON))
            rst_out <= 1'b1;
         else if (act.rst_off || (wr_ok && addr == A_RST_OFF))
            rst_out <= 1'b0;
         if (act.clk_on || (wr_ok && addr == A_CLK_ON))
            clken_out <= 1'b1;
         else if (act.clk_off || (wr_ok && addr == A_CLK_OFF))
            clken_out <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CLK_ST)      rdata[0] = clk_stat;
      else if (addr == A_RST_ST) rdata[0] = rst_stat;
   end

   // R8
   busy_write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && we && act == '0) |=> ($stable(rst_out) && $stable(clken_out)));
   // R2
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[0] && act == '0) |=> ($stable(rst_out) && $stable(clken_out)));
endmodule

// File: rtl/rcs_sequencer.sv
module rcs_sequencer
   import rcs_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT     = 1000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              seq_start,
   output logic              seq_busy,
   output logic              seq_done,
   output logic              seq_err,
   output logic [1:0]        seq_err_step,
   output logic              rst_out,
   output logic              clken_out,
   input  logic              rst_ack_in,
   input  logic              clk_ack_in
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (TIMEOUT < 2) begin : g_bad_tmo
         $error("TIMEOUT must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic     rst_stat, clk_stat;
   rcs_act_t act;

   rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk(clk), .rst_n(rst_n), .d(rst_ack_in), .q(rst_stat));
   rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clk_sync (
      .clk(clk), .rst_n(rst_n), .d(clk_ack_in), .q(clk_stat));

   rcs_seq #(.TIMEOUT(TIMEOUT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(seq_start),
      .rst_stat(rst_stat), .clk_stat(clk_stat), .act(act),
      .busy(seq_busy), .done(seq_done), .err(seq_err),
      .err_step(seq_err_step));

   rcs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .busy(seq_busy), .act(act),
      .rst_stat(rst_stat), .clk_stat(clk_stat),
      .rst_out(rst_out), .clken_out(clken_out), .rdata(reg_rdata));

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!rst_out && clken_out && !seq_busy && !seq_done && !seq_err));
endmodule

// File: tb/tb_rcs_sequencer.sv
module tb_rcs_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int AW   = 4;
   localparam int SYNC = 2;
   localparam int TMO  = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          seq_start = 1'b0;
   logic          seq_busy, seq_done, seq_err;
   logic [1:0]    seq_err_step;
   logic          rst_out, clken_out;
   logic          rst_ack, clk_ack;

   int  n_chk = 0, n_fail = 0;
   int  lat = 0;
   bit  frz_r = 0, frz_c = 0;
   bit  reported = 0;
   logic [3:0] rline, cline;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcs_sequencer #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC), .TIMEOUT(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_start(seq_start),
      .seq_busy(seq_busy), .seq_done(seq_done), .seq_err(seq_err),
      .seq_err_step(seq_err_step), .rst_out(rst_out), .clken_out(clken_out),
      .rst_ack_in(rst_ack), .clk_ack_in(clk_ack));

   // peripheral model: acknowledgement lags the output by lat+1 edges
   always @(posedge clk) begin
      if (!rst_n) begin
         rline <= 4'b0000;
         cline <= 4'b1111;
      end else begin
         if (!frz_r) rline <= {rline[2:0], rst_out};
         if (!frz_c) cline <= {cline[2:0], clken_out};
      end
   end
   assign rst_ack = rline[lat];
   assign clk_ack = cline[lat];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
      $finish;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic idle(input int c);
      for (int i = 0; i < c; i++) @(negedge clk);
   endtask

   function automatic int exp_read(input int a, input bit rs, input bit cs);
      if (a == 4) return int'(cs);
      if (a == 5) return int'(rs);
      return 0;
   endfunction

   task automatic run_seq(input int d, input int stuck, input bit intrude);
      int L, endn;
      L = d + SYNC + 2;
      endn = (stuck < 4) ? stuck * L + TMO : 4 * L;
      lat = d;
      @(negedge clk);
      seq_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      seq_start = 1'b0;
      if (stuck == 0) frz_r = 1;
      for (int n = 1; n <= endn; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (n == 1) begin
            check("R7 flags cleared at start", int'({seq_done, seq_err}), 0);
            check("R5 busy after start", int'(seq_busy), 1);
         end
         if (intrude && n == L + 1) begin
            reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = DW'(1);
            seq_start = 1'b1;
         end
         if (intrude && n == L + 2) begin
            check("R8 write ignored while busy", int'(clken_out), 0);
            reg_we = 1'b0; reg_wdata = '0; seq_start = 1'b0;
         end
         if (stuck < 4 && stuck > 0 && n == stuck * L) begin
            if (stuck == 2) frz_r = 1; else frz_c = 1;
         end
         if (n == endn - 1) check("R5 busy before end", int'(seq_busy), 1);
      end
      check("R5 busy falls at end", int'(seq_busy), 0);
      if (stuck < 4) begin
         check("R6 error flag", int'(seq_err), 1);
         check("R6 error step", int'(seq_err_step), stuck);
         check("R7 done clear on error", int'(seq_done), 0);
      end else begin
         check("R5 done flag", int'(seq_done), 1);
         check("R7 err clear on done", int'(seq_err), 0);
         check("R4 reset released", int'(rst_out), 0);
         check("R4 clock enabled", int'(clken_out), 1);
      end
      frz_r = 0; frz_c = 0;
      wr(3, 1);
      wr(0, 1);
      idle(12);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rst_out", int'(rst_out), 0);
      check("R1 clken_out", int'(clken_out), 1);
      check("R1 busy/done/err", int'({seq_busy, seq_done, seq_err}), 0);
      check("R1 err_step", int'(seq_err_step), 0);
      idle(6);
      // R3 full read sweep in default state
      for (int a = 0; a < 16; a++) begin
         reg_addr = AW'(a); #1;
         check("R3 read sweep", int'(reg_rdata), exp_read(a, 0, 1));
      end
      // R2 zero writes have no effect
      for (int a = 0; a < 4; a++) begin
         wr(a, 2);
         check("R2 zero write rst", int'(rst_out), 0);
         check("R2 zero write clk", int'(clken_out), 1);
      end
      // R2 each action register
      wr(2, 1); check("R2 set reset", int'(rst_out), 1);
      wr(1, 1); check("R2 clear clock", int'(clken_out), 0);
      idle(6);
      for (int a = 0; a < 16; a++) begin
         reg_addr = AW'(a); #1;
         check("R3 read after writes", int'(reg_rdata), exp_read(a, 1, 0));
      end
      wr(3, 1); check("R2 clear reset", int'(rst_out), 0);
      wr(0, 1); check("R2 set clock", int'(clken_out), 1);
      idle(8);
      // R4 R5 R6 latency and stuck-step sweep
      for (int d = 0; d < 4; d++)
         for (int s = 0; s <= 4; s++)
            run_seq(d, s, 1'b0);
      // R8 intrusion during a run
      run_seq(1, 4, 1'b1);
      report();
   end
endmodule